// File: doc/BRIEF.md
# Hash Join Bit-Vector Filter

This block finds equal join keys between two tables streamed through it one after the other. During the build phase it accepts (join key, row address) pairs from the smaller table. Each key is folded into a bucket index. The bucket's bit is set in an on-chip presence vector, and the key and address go into an on-chip entry table. Entries that land in the same bucket are linked into a chain, with the newest entry first. Full rows are never held here.

During the probe phase it accepts (join key, probe row id) pairs. A probe whose bucket bit is clear is dropped in the same cycle. A probe whose bit is set starts a walk along the bucket's chain, one entry per cycle. Each stored key is compared with the probe key, so false positives from the hash are removed. Only exact matches reach the output as (build row address, probe row id). Each output triggers an off-chip row fetch downstream, so false positives must never get that far. A single-cycle clear command empties the structure between join jobs.

Top module: `hash_join_filter`

## Requirements
- R1: After reset, buildReady and probeReady are high, and matchValid and overflow are low.
- R2: The bucket index is an XOR fold of the key: key bit i feeds index bit (i mod HASH_W). With the defaults (32-bit key, HASH_W=10), key and key^0x401 share a bucket.
- R3: buildReady stays high while fewer than DEPTH entries are stored. A build pair is stored when buildValid is high in a cycle with buildReady high.
- R4: A build pair offered while the table is full is not stored. It sets overflow, and overflow stays high until a clear.
- R5: A probe accepted while its bucket bit is clear produces no output, and probeReady stays high in the next cycle.
- R6: A probe accepted at clock edge E whose bucket holds L entries drops probeReady for edges E+1 to E+L. The entry compared at edge E+k (k=1 is the newest) raises matchValid after that edge when its key equals the probe key. One output is produced per equal entry, newest first.
- R7: Entries in the same bucket whose keys differ from the probe key produce no output.
- R8: With matchValid high, matchAddr carries the matched entry's build row address and matchId carries the probe row id.
- R9: clearReq empties the table in one cycle. After it, overflow and matchValid are low, both ready outputs are high, any walk is aborted, and earlier build keys no longer match. A build or probe offered in the same cycle as clearReq is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clearReq | input | 1 | Empty the table and abort any walk |
| buildValid | input | 1 | Build pair offered |
| buildReady | output | 1 | Table has room |
| buildKey | input | KEY_W | Build join key |
| buildAddr | input | ADDR_W | Build row address |
| probeValid | input | 1 | Probe pair offered |
| probeReady | output | 1 | No chain walk in progress |
| probeKey | input | KEY_W | Probe join key |
| probeId | input | ID_W | Probe row id |
| matchValid | output | 1 | A true match is presented |
| matchAddr | output | ADDR_W | Build row address of the match |
| matchId | output | ID_W | Probe row id of the match |
| overflow | output | 1 | A build pair was refused since the last clear |

## Verification
The assertions assume that every input is at a known level once reset is released. They also assume that a source treats a pair as taken only in a cycle where the matching ready output is high. A pair offered while ready is low is expected to be offered again, not lost. The stimulus keeps to this: the directed probes wait for probeReady before asserting probeValid. The random phase may assert probeValid at any time, and its reference model counts an offer as taken only when probeReady was high. The random phase also mixes builds, probes and clears in the same cycle. The reference model handles this by applying clear first, then the probe against the table as it stood before the edge, then the build.

// File: rtl/hj_pkg.sv
package hj_pkg;

  typedef struct packed {
    logic clearAll;
    logic buildWrite;
    logic probeLoad;
    logic walkStep;
  } hj_strobe_t;

  typedef enum logic {
    PROBE_IDLE = 1'b0,
    PROBE_WALK = 1'b1
  } probe_state_t;

endpackage

// File: rtl/hj_datapath.sv
module hj_datapath
  import hj_pkg::*;
#(
  parameter int KEY_W  = 32,
  parameter int ADDR_W = 32,
  parameter int ID_W   = 16,
  parameter int HASH_W = 10,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hj_strobe_t        strobe,
  input  logic [KEY_W-1:0]  buildKey,
  input  logic [ADDR_W-1:0] buildAddr,
  input  logic [KEY_W-1:0]  probeKey,
  input  logic [ID_W-1:0]   probeId,
  output logic              tableFull,
  output logic              probeHit,
  output logic              chainLast,
  output logic              matchValid,
  output logic [ADDR_W-1:0] matchAddr,
  output logic [ID_W-1:0]   matchId
);

  localparam int NBUCK = 1 << HASH_W;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PTR_W = IDX_W + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] END_PTR = {1'b1, {IDX_W{1'b0}}};

  function automatic logic [HASH_W-1:0] foldKey(input logic [KEY_W-1:0] k);
    logic [HASH_W-1:0] f;
    f = '0;
    for (int i = 0; i < KEY_W; i++) begin
      f[i % HASH_W] = f[i % HASH_W] ^ k[i];
    end
    return f;
  endfunction

  logic [NBUCK-1:0]  bitVec;
  logic [IDX_W-1:0]  headMem [NBUCK];
  logic [KEY_W-1:0]  keyMem  [DEPTH];
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [PTR_W-1:0]  nextMem [DEPTH];

  logic [CNT_W-1:0]  fillCnt;
  logic [IDX_W-1:0]  walkPtr;
  logic [KEY_W-1:0]  heldKey;
  logic [ID_W-1:0]   heldId;

  logic [HASH_W-1:0] buildHash;
  logic [HASH_W-1:0] probeHash;
  logic [IDX_W-1:0]  wrIdx;
  logic [PTR_W-1:0]  walkLink;

  assign buildHash = foldKey(buildKey);
  assign probeHash = foldKey(probeKey);
  assign wrIdx     = IDX_W'(fillCnt);
  assign walkLink  = nextMem[walkPtr];

  assign tableFull = (fillCnt == CNT_W'(DEPTH));
  assign probeHit  = bitVec[probeHash];
  assign chainLast = walkLink[PTR_W-1];

  // presence vector and fill count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitVec  <= '0;
      fillCnt <= '0;
    end else if (strobe.clearAll) begin
      bitVec  <= '0;
      fillCnt <= '0;
    end else if (strobe.buildWrite) begin
      bitVec[buildHash] <= 1'b1;
      fillCnt           <= fillCnt + 1'b1;
    end
  end

  // entry storage, chained newest first
  always_ff @(posedge clk) begin
    if (strobe.buildWrite) begin
      keyMem[wrIdx]      <= buildKey;
      addrMem[wrIdx]     <= buildAddr;
      nextMem[wrIdx]     <= bitVec[buildHash] ? {1'b0, headMem[buildHash]} : END_PTR;
      headMem[buildHash] <= wrIdx;
    end
  end

  // probe holding registers and chain cursor
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walkPtr <= '0;
      heldKey <= '0;
      heldId  <= '0;
    end else if (strobe.probeLoad) begin
      walkPtr <= headMem[probeHash];
      heldKey <= probeKey;
      heldId  <= probeId;
    end else if (strobe.walkStep) begin
      walkPtr <= walkLink[IDX_W-1:0];
    end
  end

  // registered match output
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      matchValid <= 1'b0;
      matchAddr  <= '0;
      matchId    <= '0;
    end else begin
      matchValid <= strobe.walkStep && (keyMem[walkPtr] == heldKey);
      if (strobe.walkStep) begin
        matchAddr <= addrMem[walkPtr];
        matchId   <= heldId;
      end
    end
  end

endmodule

// File: rtl/hj_control.sv
module hj_control
  import hj_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clearReq,
  input  logic       buildValid,
  input  logic       probeValid,
  input  logic       tableFull,
  input  logic       probeHit,
  input  logic       chainLast,
  output hj_strobe_t strobe,
  output logic       buildReady,
  output logic       probeReady,
  output logic       overflow
);

  probe_state_t state;
  probe_state_t stateNext;

  assign buildReady = !tableFull;
  assign probeReady = (state == PROBE_IDLE);

  always_comb begin
    strobe.clearAll   = clearReq;
    strobe.buildWrite = buildValid && !tableFull && !clearReq;
    strobe.probeLoad  = (state == PROBE_IDLE) && probeValid && probeHit && !clearReq;
    strobe.walkStep   = (state == PROBE_WALK) && !clearReq;
  end

  always_comb begin
    stateNext = state;
    if (clearReq) begin
      stateNext = PROBE_IDLE;
    end else if (strobe.probeLoad) begin
      stateNext = PROBE_WALK;
    end else if (strobe.walkStep && chainLast) begin
      stateNext = PROBE_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PROBE_IDLE;
      overflow <= 1'b0;
    end else begin
      state <= stateNext;
      if (clearReq) begin
        overflow <= 1'b0;
      end else if (buildValid && tableFull) begin
        overflow <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hash_join_filter.sv
module hash_join_filter
  import hj_pkg::*;
#(
  parameter int KEY_W  = 32,
  parameter int ADDR_W = 32,
  parameter int ID_W   = 16,
  parameter int HASH_W = 10,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clearReq,
  input  logic              buildValid,
  output logic              buildReady,
  input  logic [KEY_W-1:0]  buildKey,
  input  logic [ADDR_W-1:0] buildAddr,
  input  logic              probeValid,
  output logic              probeReady,
  input  logic [KEY_W-1:0]  probeKey,
  input  logic [ID_W-1:0]   probeId,
  output logic              matchValid,
  output logic [ADDR_W-1:0] matchAddr,
  output logic [ID_W-1:0]   matchId,
  output logic              overflow
);

  hj_strobe_t strobe;
  logic tableFull;
  logic probeHit;
  logic chainLast;

  hj_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clearReq   (clearReq),
    .buildValid (buildValid),
    .probeValid (probeValid),
    .tableFull  (tableFull),
    .probeHit   (probeHit),
    .chainLast  (chainLast),
    .strobe     (strobe),
    .buildReady (buildReady),
    .probeReady (probeReady),
    .overflow   (overflow)
  );

  hj_datapath #(
    .KEY_W  (KEY_W),
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .HASH_W (HASH_W),
    .DEPTH  (DEPTH)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .buildKey   (buildKey),
    .buildAddr  (buildAddr),
    .probeKey   (probeKey),
    .probeId    (probeId),
    .tableFull  (tableFull),
    .probeHit   (probeHit),
    .chainLast  (chainLast),
    .matchValid (matchValid),
    .matchAddr  (matchAddr),
    .matchId    (matchId)
  );

endmodule

// File: rtl/hash_join_filter_checker.sv
module hash_join_filter_checker #(
  parameter int KEY_W  = 32,
  parameter int ADDR_W = 32,
  parameter int ID_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clearReq,
  input logic              buildValid,
  input logic              buildReady,
  input logic [KEY_W-1:0]  buildKey,
  input logic [ADDR_W-1:0] buildAddr,
  input logic              probeValid,
  input logic              probeReady,
  input logic [KEY_W-1:0]  probeKey,
  input logic [ID_W-1:0]   probeId,
  input logic              matchValid,
  input logic [ADDR_W-1:0] matchAddr,
  input logic [ID_W-1:0]   matchId,
  input logic              overflow
);

  // R4: overflow only rises after a refused build offer
  a_r4_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(buildValid && !buildReady));

  // R3: a full table stays full until cleared
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!buildReady && !clearReq) |=> !buildReady);

  // R6: every match comes out of a chain walk
  a_r6_match_from_walk: assert property (@(posedge clk) disable iff (!rst_n)
    matchValid |-> !$past(probeReady));

  // R6: a walk starts only from an offered probe
  a_r6_walk_needs_probe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(probeReady) |-> $past(probeValid));

  // R9: clear leaves an empty, idle block
  a_r9_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    clearReq |=> (!matchValid && !overflow && buildReady && probeReady));

endmodule

bind hash_join_filter hash_join_filter_checker #(
  .KEY_W  (KEY_W),
  .ADDR_W (ADDR_W),
  .ID_W   (ID_W)
) u_chk (.*);

// File: tb/hash_join_filter_test.sv
module hash_join_filter_test;

  localparam int KEY_W  = 32;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 16;
  localparam int HASH_W = 10;
  localparam int DEPTH  = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clearReq = 1'b0;
  logic buildValid = 1'b0;
  logic [KEY_W-1:0] buildKey = '0;
  logic [ADDR_W-1:0] buildAddr = '0;
  logic probeValid = 1'b0;
  logic [KEY_W-1:0] probeKey = '0;
  logic [ID_W-1:0] probeId = '0;
  logic buildReady, probeReady, matchValid, overflow;
  logic [ADDR_W-1:0] matchAddr;
  logic [ID_W-1:0] matchId;

  always #10 clk = ~clk;

  hash_join_filter #(
    .KEY_W(KEY_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .HASH_W(HASH_W), .DEPTH(DEPTH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .clearReq(clearReq),
    .buildValid(buildValid), .buildReady(buildReady), .buildKey(buildKey), .buildAddr(buildAddr),
    .probeValid(probeValid), .probeReady(probeReady), .probeKey(probeKey), .probeId(probeId),
    .matchValid(matchValid), .matchAddr(matchAddr), .matchId(matchId), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  string scen = "R1";

  // R2: reference fold, bit i feeds bucket bit i mod HASH_W
  function automatic logic [HASH_W-1:0] refHash(input logic [KEY_W-1:0] k);
    logic [HASH_W-1:0] f = '0;
    for (int i = 0; i < KEY_W; i++) f[i % HASH_W] ^= k[i];
    return f;
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", scen, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [KEY_W-1:0]  mKey[$];
  logic [ADDR_W-1:0] mAddr[$];
  bit                wHit[$];
  logic [ADDR_W-1:0] wAddr[$];
  logic [ID_W-1:0]   mHeld;
  bit mOvf, expMv;
  logic [ADDR_W-1:0] expMa;
  logic [ID_W-1:0]   expMi;
  bit rdy;

  always @(posedge clk) begin
    if (!rst_n) begin
      mKey.delete(); mAddr.delete(); wHit.delete(); wAddr.delete();
      mOvf = 0; expMv = 0;
    end else begin
      rdy = (wHit.size() == 0);
      if (clearReq) begin
        mKey.delete(); mAddr.delete(); wHit.delete(); wAddr.delete();
        mOvf = 0; expMv = 0;
      end else begin
        expMv = 0;
        if (!rdy) begin
          expMv = wHit.pop_front();
          expMa = wAddr.pop_front();
          expMi = mHeld;
        end else if (probeValid) begin
          for (int i = mKey.size() - 1; i >= 0; i--) begin
            if (refHash(mKey[i]) == refHash(probeKey)) begin
              wHit.push_back(mKey[i] == probeKey);
              wAddr.push_back(mAddr[i]);
            end
          end
          mHeld = probeId;
        end
        if (buildValid) begin
          if (mKey.size() < DEPTH) begin
            mKey.push_back(buildKey);
            mAddr.push_back(buildAddr);
          end else begin
            mOvf = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(64'(buildReady), 64'(mKey.size() < DEPTH), "R3 buildReady");
      check(64'(overflow),   64'(mOvf),                "R4 overflow");
      check(64'(probeReady), 64'(wHit.size() == 0),    "R6 probeReady");
      check(64'(matchValid), 64'(expMv),               "R6 matchValid");
      if (expMv) begin
        check(64'(matchAddr), 64'(expMa), "R8 matchAddr");
        check(64'(matchId),   64'(expMi), "R8 matchId");
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic build(input logic [KEY_W-1:0] k, input logic [ADDR_W-1:0] a);
    buildValid = 1; buildKey = k; buildAddr = a;
    tick();
    buildValid = 0;
  endtask

  task automatic probe(input logic [KEY_W-1:0] k, input logic [ID_W-1:0] id);
    while (!probeReady) tick();
    probeValid = 1; probeKey = k; probeId = id;
    tick();
    probeValid = 0;
  endtask

  task automatic drain();
    tick();
    while (!probeReady) tick();
    tick();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1: reset state
    check(64'(buildReady), 64'd1, "R1 buildReady");
    check(64'(probeReady), 64'd1, "R1 probeReady");
    check(64'(matchValid), 64'd0, "R1 matchValid");
    check(64'(overflow),   64'd0, "R1 overflow");

    // R3 and R2: builds with duplicates and bucket colliders
    scen = "R3";
    build(32'h0000_1234, 32'hA000_0001);
    build(32'h0000_1234 ^ 32'h401, 32'hA000_0002);
    build(32'h0000_1234, 32'hA000_0003);
    build(32'h0000_0055, 32'hA000_0004);
    build(32'h0000_1234 ^ 32'h802, 32'hA000_0005);
    build(32'hDEAD_BEEF, 32'hA000_0006);
    tick();

    // R2: collider key must share the bucket (walk length 4 for this probe)
    scen = "R2";
    check(64'(refHash(32'h1234)), 64'(refHash(32'h1234 ^ 32'h401)), "R2 fold");
    probe(32'h0000_1234 ^ 32'h401, 16'h0011);
    drain();

    // R5: keys with clear buckets
    scen = "R5";
    probe(32'h0000_0001, 16'h0021);
    check(64'(probeReady), 64'd1, "R5 ready after clear bucket");
    probe(32'h7777_0000, 16'h0022);
    tick();

    // R6: duplicate key, multiple outputs newest first
    scen = "R6";
    probe(32'h0000_1234, 16'h0031);
    drain();

    // R7: same bucket, no equal key
    scen = "R7";
    probe(32'h0000_1234 ^ 32'hC03, 16'h0041);
    drain();

    // R8: back-to-back probes
    scen = "R8";
    probe(32'h0000_0055, 16'h0051);
    probe(32'hDEAD_BEEF, 16'h0052);
    probe(32'h0000_1234 ^ 32'h802, 16'h0053);
    drain();

    // R9: clear, then old keys do not match
    scen = "R9";
    clearReq = 1; tick(); clearReq = 0;
    probe(32'h0000_1234, 16'h0061);
    drain();
    check(64'(matchValid), 64'd0, "R9 no match after clear");

    // R4: fill the table, offer more, then clear
    scen = "R4";
    for (int i = 0; i < DEPTH; i++) build(32'(i * 7 + 3), 32'(i));
    tick();
    check(64'(buildReady), 64'd0, "R4 full");
    build(32'h0000_0003, 32'hFFFF_0000);
    build(32'h0000_0AAA, 32'hFFFF_0001);
    tick();
    check(64'(overflow), 64'd1, "R4 overflow set");
    probe(32'h0000_0003, 16'h0071);
    drain();
    scen = "R9";
    clearReq = 1; tick(); clearReq = 0;
    check(64'(overflow), 64'd0, "R9 overflow cleared");

    // mixed random traffic over a small key pool
    scen = "R6";
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      buildValid = (r < 35);
      buildKey   = 32'($urandom_range(0, 5)) ^ (($urandom_range(0, 1) != 0) ? 32'h401 : 32'h0);
      buildAddr  = 32'($urandom);
      probeValid = ($urandom_range(0, 99) < 50);
      probeKey   = 32'($urandom_range(0, 7)) ^ (($urandom_range(0, 1) != 0) ? 32'h401 : 32'h0);
      probeId    = 16'($urandom);
      clearReq   = ($urandom_range(0, 199) == 0);
      tick();
    end
    buildValid = 0; probeValid = 0; clearReq = 0;
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule